// File: doc/BRIEF.md
# Gate Supply Undervoltage Supervisor

This block watches the supplies of a three-phase gate stage and decides when the gate outputs may drive. Its inputs are undervoltage flags from analog comparators: one for the gate supply that all six gate outputs share, and one for each phase's bootstrap supply. It also watches the three high-side PWM commands. Each flag passes through a counter filter, so a glitch shorter than the programmed window has no effect. The filtered results drive one global gate enable and one high-side enable per phase.

The two kinds of fault recover in different ways. A gate-supply fault removes every enable, and those enables come back by themselves once the supply has been good for a full filter window. A bootstrap fault removes only that phase's high-side enable. That phase stays off after its supply recovers, until its PWM command makes a fresh low-to-high transition. This keeps a half-charged bootstrap capacitor from being switched in partway through a PWM period. A set of sticky status bits records each fault source until software clears it with a write-one pulse.

Top module: `uvlo_supervisor`

## Requirements
- R1: While the filtered gate-supply state is faulted, `gate_en` is 0 and every bit of `hs_en` is 0.
- R2: When the gate-supply flag has read good for DEGLITCH consecutive clock edges, `gate_en` returns to 1 with no other action. Each phase whose high side was armed before the fault gets its `hs_en` back without a new PWM edge.
- R3: When a phase's filtered bootstrap state is faulted, that phase's `hs_en` is 0. The other phases and `gate_en` are not affected.
- R4: A filtered state changes only at the DEGLITCH-th consecutive edge on which the raw flag differs from it. This rule holds for both entering and leaving a fault. A raw excursion shorter than DEGLITCH edges changes no output.
- R5: After reset, all enables are 0 and all status bits are 0. The supply states start as faulted. With the gate-supply flag good, `gate_en` becomes 1 exactly DEGLITCH edges after reset is released.
- R6: A phase arms when its PWM command is sampled 0 at one edge and 1 at the next edge, and its filtered bootstrap state was good before that edge. `hs_en` then rises right after that edge, provided `gate_en` is 1. Phases start disarmed after reset.
- R7: A PWM rise that is sampled while the bootstrap state is faulted does not arm the phase. The same holds for a rise sampled at the very edge where the fault clears. A command held high through the recovery leaves the phase disarmed.
- R8: `status_q` bit 0 records the gate supply and bit p+1 records phase p. A bit sets on the edge at which its filtered state enters the fault. It holds until a clock edge sees the matching `status_clr` bit at 1. If a set and a clear happen at the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gsup_uv_raw | input | 1 | Gate-supply comparator flag, 1 = undervoltage |
| boot_uv_raw | input | PHASES | Bootstrap comparator flag per phase, 1 = undervoltage |
| hs_pwm | input | PHASES | High-side PWM command per phase |
| status_clr | input | PHASES+1 | Write-one-to-clear pulses for `status_q` |
| gate_en | output | 1 | Global enable for all gate outputs |
| hs_en | output | PHASES | High-side enable per phase |
| gsup_fault | output | 1 | Filtered gate-supply fault state |
| boot_fault | output | PHASES | Filtered bootstrap fault state per phase |
| status_q | output | PHASES+1 | Sticky fault record |

## Verification
The bound assertions check several rules on every cycle. Every enable is off while the gate supply is down. No filtered state flips before the raw flag has held its new value for a full window, which the checker measures with run-length counters. A high-side enable rises, outside of gate-supply recovery, only right after a sampled PWM rise. A status bit is set whenever its filtered state enters a fault. Some behaviour can only be shown by the bench's scenarios: a PWM rise at the very edge where a bootstrap fault clears does not arm; a command held high through recovery leaves the phase dark; armed phases come back after a gate-supply fault; and a clear that coincides with a new fault loses. The random phase compares every output on every cycle against a cycle model built from the requirements.

// File: rtl/uvlo_pkg.sv
package uvlo_pkg;
  // status vector layout: gate supply first, then phases in order
  localparam int unsigned STAT_GSUP = 0;

  function automatic int unsigned stat_boot(input int unsigned phase);
    return phase + 1;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned cycles);
    return (cycles < 2) ? 1 : $clog2(cycles + 1);
  endfunction
endpackage

// File: rtl/uvlo_deglitch.sv
module uvlo_deglitch #(
  parameter int unsigned CYCLES = 2000,
  parameter bit          INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o,
  output logic enter_o
);
  localparam int unsigned CW   = uvlo_pkg::cnt_width(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;
  logic          differ, expire, cnt_en;

  always_comb begin
    differ  = raw_i ^ filt_q;
    expire  = differ && (cnt_q == LAST);
    cnt_en  = differ || (cnt_q != '0);
    cnt_d   = (differ && !expire) ? cnt_q + 1'b1 : '0;
    filt_d  = expire ? raw_i : filt_q;
    enter_o = expire && raw_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= INIT;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (expire) filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/uvlo_hs_arm.sv
module uvlo_hs_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic pwm_i,
  output logic armed_o
);
  logic pwm_q;
  logic armed_q, armed_d;
  logic rise;

  always_comb begin
    rise = pwm_i && !pwm_q;
    if (fault_i)   armed_d = 1'b0;
    else if (rise) armed_d = 1'b1;
    else           armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      pwm_q   <= pwm_i;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/uvlo_status_bank.sv
module uvlo_status_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q, q_d, en;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      en[i]  = set_i[i] || clr_i[i];
      q_d[i] = set_i[i] ? 1'b1 : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_q[i] <= 1'b0;
      else if (en[i]) q_q[i] <= q_d[i];
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/uvlo_supervisor.sv
module uvlo_supervisor #(
  parameter int unsigned PHASES   = 3,
  parameter int unsigned DEGLITCH = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gsup_uv_raw,
  input  logic [PHASES-1:0] boot_uv_raw,
  input  logic [PHASES-1:0] hs_pwm,
  input  logic [PHASES:0]   status_clr,
  output logic              gate_en,
  output logic [PHASES-1:0] hs_en,
  output logic              gsup_fault,
  output logic [PHASES-1:0] boot_fault,
  output logic [PHASES:0]   status_q
);
  localparam int unsigned NSTAT = PHASES + 1;

  logic              gsup_f, gsup_enter;
  logic [PHASES-1:0] boot_f, boot_enter, armed;
  logic [NSTAT-1:0]  stat_set;

  uvlo_deglitch #(.CYCLES(DEGLITCH), .INIT(1'b1)) u_gsup_flt (
    .clk(clk), .rst_n(rst_n), .raw_i(gsup_uv_raw),
    .filt_o(gsup_f), .enter_o(gsup_enter)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    uvlo_deglitch #(.CYCLES(DEGLITCH), .INIT(1'b1)) u_boot_flt (
      .clk(clk), .rst_n(rst_n), .raw_i(boot_uv_raw[p]),
      .filt_o(boot_f[p]), .enter_o(boot_enter[p])
    );

    uvlo_hs_arm u_arm (
      .clk(clk), .rst_n(rst_n), .fault_i(boot_f[p]),
      .pwm_i(hs_pwm[p]), .armed_o(armed[p])
    );

    assign stat_set[uvlo_pkg::stat_boot(p)] = boot_enter[p];
  end

  assign stat_set[uvlo_pkg::STAT_GSUP] = gsup_enter;

  uvlo_status_bank #(.N(NSTAT)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(stat_set),
    .clr_i(status_clr), .q_o(status_q)
  );

  always_comb begin
    gate_en    = !gsup_f;
    hs_en      = {PHASES{gate_en}} & armed & ~boot_f;
    gsup_fault = gsup_f;
    boot_fault = boot_f;
  end
endmodule

// File: rtl/uvlo_supervisor_chk.sv
module uvlo_supervisor_chk #(
  parameter int unsigned PHASES   = 3,
  parameter int unsigned DEGLITCH = 2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gsup_uv_raw,
  input logic [PHASES-1:0] boot_uv_raw,
  input logic [PHASES-1:0] hs_pwm,
  input logic [PHASES:0]   status_clr,
  input logic              gate_en,
  input logic [PHASES-1:0] hs_en,
  input logic              gsup_fault,
  input logic [PHASES-1:0] boot_fault,
  input logic [PHASES:0]   status_q
);
  int unsigned gs_bad, gs_good;
  int unsigned bt_bad [PHASES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gs_bad  <= 0;
      gs_good <= 0;
    end else begin
      gs_bad  <= gsup_uv_raw  ? ((gs_bad  < DEGLITCH) ? gs_bad  + 1 : gs_bad)  : 0;
      gs_good <= !gsup_uv_raw ? ((gs_good < DEGLITCH) ? gs_good + 1 : gs_good) : 0;
    end
  end

  assert_gate_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> (hs_en == '0));

  assert_gate_bad_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gs_bad >= DEGLITCH) |-> !gate_en);

  assert_recover_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> (gs_good >= DEGLITCH));

  assert_deglitch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_en) |-> (gs_bad >= DEGLITCH));

  assert_sticky_gsup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_en) |-> status_q[0]);

  for (genvar p = 0; p < PHASES; p++) begin : g_chk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bt_bad[p] <= 0;
      else        bt_bad[p] <= boot_uv_raw[p] ?
                    ((bt_bad[p] < DEGLITCH) ? bt_bad[p] + 1 : bt_bad[p]) : 0;
    end

    assert_phase_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bt_bad[p] >= DEGLITCH) |-> (!hs_en[p] && boot_fault[p]));

    assert_boot_deglitch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boot_fault[p]) |-> (bt_bad[p] >= DEGLITCH));

    assert_arm_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hs_en[p]) && $past(gate_en)) |-> ($past(hs_pwm[p]) && !$past(hs_pwm[p], 2)));

    assert_sticky_boot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boot_fault[p]) |-> status_q[p+1]);
  end
endmodule

bind uvlo_supervisor uvlo_supervisor_chk #(.PHASES(PHASES), .DEGLITCH(DEGLITCH)) u_chk (.*);

// File: tb/uvlo_supervisor_test.sv
module uvlo_supervisor_test;
  localparam int PH = 3;
  localparam int DG = 8;

  logic          clk;
  logic          rst_n;
  logic          gsup_uv_raw;
  logic [PH-1:0] boot_uv_raw;
  logic [PH-1:0] hs_pwm;
  logic [PH:0]   status_clr;
  logic          gate_en;
  logic [PH-1:0] hs_en;
  logic          gsup_fault;
  logic [PH-1:0] boot_fault;
  logic [PH:0]   status_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // cycle model state: index 0 = gate supply, 1..PH = phases
  bit       m_f  [PH+1];
  int       m_c  [PH+1];
  bit       m_arm[PH];
  bit       m_hq [PH];
  bit [PH:0] m_st;

  uvlo_supervisor #(.PHASES(PH), .DEGLITCH(DG)) uut (
    .clk(clk), .rst_n(rst_n), .gsup_uv_raw(gsup_uv_raw), .boot_uv_raw(boot_uv_raw),
    .hs_pwm(hs_pwm), .status_clr(status_clr), .gate_en(gate_en), .hs_en(hs_en),
    .gsup_fault(gsup_fault), .boot_fault(boot_fault), .status_q(status_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit raw_of(int i);
    return (i == 0) ? gsup_uv_raw : boot_uv_raw[i-1];
  endfunction

  function automatic bit exp_gate();
    return !m_f[0];
  endfunction

  function automatic bit [PH-1:0] exp_hs();
    bit [PH-1:0] r;
    for (int p = 0; p < PH; p++) r[p] = exp_gate() && m_arm[p] && !m_f[p+1];
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i <= PH; i++) begin m_f[i] = 1'b1; m_c[i] = 0; end
    for (int p = 0; p < PH; p++) begin m_arm[p] = 1'b0; m_hq[p] = 1'b0; end
    m_st = '0;
  endtask

  task automatic model_step();
    bit [PH:0] enter;
    enter = '0;
    for (int p = 0; p < PH; p++) begin
      if (m_f[p+1]) m_arm[p] = 1'b0;
      else if (hs_pwm[p] && !m_hq[p]) m_arm[p] = 1'b1;
      m_hq[p] = hs_pwm[p];
    end
    for (int i = 0; i <= PH; i++) begin
      if (raw_of(i) != m_f[i]) begin
        if (m_c[i] == DG - 1) begin
          m_f[i] = raw_of(i); m_c[i] = 0; enter[i] = raw_of(i);
        end else m_c[i]++;
      end else m_c[i] = 0;
    end
    m_st = (m_st & ~status_clr) | enter;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(gate_en == exp_gate(), "R1/R2 gate_en", 32'(gate_en), 32'(exp_gate()));
    chk(hs_en == exp_hs(), "R3/R6 hs_en", 32'(hs_en), 32'(exp_hs()));
    chk(status_q == m_st, "R8 status_q", 32'(status_q), 32'(m_st));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    status_clr = '0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; gsup_uv_raw = 1'b0; boot_uv_raw = '0; hs_pwm = '0; status_clr = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R5: reset state
    chk(gate_en == 1'b0 && hs_en == '0, "R5 enables in reset", {hs_en, gate_en}, 0);
    chk(status_q == '0, "R5 status in reset", 32'(status_q), 0);
    rst_n = 1'b1;

    // R5: gate enable appears exactly DG edges after release
    ticks(DG - 1);
    chk(gate_en == 1'b0, "R5 gate_en before window", 32'(gate_en), 0);
    tick();
    chk(gate_en == 1'b1, "R5 gate_en at window", 32'(gate_en), 1);
    chk(hs_en == '0, "R6 not armed without edge", 32'(hs_en), 0);

    // R6: PWM rise arms each phase
    hs_pwm = '1;
    tick();
    chk(hs_en == '1, "R6 armed after rise", 32'(hs_en), 32'h7);

    // R4: short gate-supply glitch ignored
    gsup_uv_raw = 1'b1; ticks(DG - 1); gsup_uv_raw = 1'b0; tick();
    chk(gate_en == 1'b1 && hs_en == '1, "R4 glitch ignored", {hs_en, gate_en}, 32'hF);

    // R3/R8: phase 1 bootstrap fault only affects phase 1
    boot_uv_raw[1] = 1'b1; ticks(DG);
    chk(hs_en == 3'b101, "R3 phase 1 isolated", 32'(hs_en), 32'h5);
    chk(status_q[2] == 1'b1, "R8 phase 1 sticky", 32'(status_q), 32'h4);

    // R7: command held high through recovery stays disarmed
    boot_uv_raw[1] = 1'b0; ticks(DG + 2);
    chk(hs_en[1] == 1'b0, "R7 held command no arm", 32'(hs_en), 32'h5);

    // R7: rise at the very edge where fault clears does not arm
    boot_uv_raw[1] = 1'b1; ticks(DG);
    hs_pwm[1] = 1'b0; tick();
    boot_uv_raw[1] = 1'b0; ticks(DG - 1);
    hs_pwm[1] = 1'b1; tick();
    chk(boot_fault[1] == 1'b0 && hs_en[1] == 1'b0, "R7 same-edge rise", 32'(hs_en), 32'h5);
    hs_pwm[1] = 1'b0; tick(); hs_pwm[1] = 1'b1; tick();
    chk(hs_en == '1, "R6 fresh rise rearms", 32'(hs_en), 32'h7);

    // R1/R2: gate-supply fault, then automatic recovery keeps arming
    gsup_uv_raw = 1'b1; ticks(DG);
    chk(gate_en == 1'b0 && hs_en == '0, "R1 all off", {hs_en, gate_en}, 0);
    gsup_uv_raw = 1'b0; ticks(DG);
    chk(gate_en == 1'b1 && hs_en == '1, "R2 auto recover", {hs_en, gate_en}, 32'hF);

    // R8: clear pulses
    status_clr = 4'b0101; tick();
    chk(status_q == '0, "R8 cleared", 32'(status_q), 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 59) == 0) gsup_uv_raw = ~gsup_uv_raw;
      for (int p = 0; p < PH; p++) begin
        if ($urandom_range(0, 29) == 0) boot_uv_raw[p] = ~boot_uv_raw[p];
        if ($urandom_range(0, 3) == 0) hs_pwm[p] = ~hs_pwm[p];
      end
      if ($urandom_range(0, 9) == 0) status_clr = 4'($urandom_range(0, 15));
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule